// File: doc/BRIEF.md
# Processor Clock, Reset and Ready Generator

This block turns one fast source clock into the timing a small processor system runs on. A select input picks the source: the on-board oscillator input or an external frequency input. From that source the block produces a processor clock at one third of the source rate, high for one source cycle in three. It also produces a peripheral clock at half the processor rate, which is one sixth of the source rate, with an even duty cycle. The raw oscillator input is passed straight to an output for devices that need the undivided rate.

An active-low reset request becomes an active-high reset for the processor. The request is clocked through a short synchronizer that advances on processor-clock rises. The reset output is released only on a processor-clock fall, so the processor sees a clean release. Two ready sources, each qualified by its own active-low enable, are merged into one ready output. A mode input chooses between a direct path with one sampling stage and a tolerant path with two stages for slow ready sources. Removal of ready is never delayed by the synchronizer.

Top module: `proc_clk_gen`

## Requirements
- R1: `cpu_clk_o` has a period of exactly 3 source-clock cycles and is high for exactly 1 of them.
- R2: `per_clk_o` has a period of 6 source cycles and is high for 3 of them. It changes only on a cycle where `cpu_clk_o` rises.
- R3: With `sel_ext_i` low, the dividers count `osc_in_i` cycles. With `sel_ext_i` high, they count `ext_freq_i` cycles. The select is changed only while `res_n_i` is low.
- R4: `osc_o` follows `osc_in_i` undivided at all times.
- R5: While `res_n_i` is low, `reset_o` is high and both `cpu_clk_o` and `per_clk_o` are held low.
- R6: After `res_n_i` rises, `reset_o` stays high for two processor-clock rises. It falls on the source edge where `cpu_clk_o` falls, which is the 7th source edge after release. Once low, it stays low until the next reset request.
- R7: A ready request exists when (`rdy1_i` high and `aen1_n_i` low) or (`rdy2_i` high and `aen2_n_i` low). A ready input whose enable is high has no effect on `ready_o`.
- R8: With `async_n_i` high (direct mode), a request is sampled at a processor-clock rise and `ready_o` rises on that edge. With `async_n_i` low (tolerant mode), the request sampled at a rise reaches `ready_o` at the following processor-clock fall, one source cycle later.
- R9: When the request goes away, `ready_o` falls at the next processor-clock edge, rising or falling, in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_in_i | input | 1 | Oscillator source clock |
| ext_freq_i | input | 1 | External frequency source clock |
| sel_ext_i | input | 1 | Source select: 0 oscillator, 1 external |
| res_n_i | input | 1 | Active-low reset request |
| rdy1_i | input | 1 | Ready source 1 |
| aen1_n_i | input | 1 | Active-low enable for ready source 1 |
| rdy2_i | input | 1 | Ready source 2 |
| aen2_n_i | input | 1 | Active-low enable for ready source 2 |
| async_n_i | input | 1 | Ready mode: 0 tolerant two-stage, 1 direct one-stage |
| osc_o | output | 1 | Undivided oscillator output |
| cpu_clk_o | output | 1 | Processor clock, source divided by 3, 1/3 duty |
| per_clk_o | output | 1 | Peripheral clock, source divided by 6, 1/2 duty |
| reset_o | output | 1 | Active-high processor reset |
| ready_o | output | 1 | Synchronized ready |

## Verification
If the phase counter leaves its range or skips a state, the processor-clock period or high time goes wrong within one 3-cycle period. A peripheral toggle out of step shows up as an uneven 6-cycle period. If a synchronizer stage is missing or misordered, the reset release moves off its 7th-edge slot or off a processor-clock fall. The ready latency also changes: 3 source edges in direct mode and 4 in tolerant mode, measured from just after a rise. A stale ready stage shows as `ready_o` lingering past the first processor-clock edge after the request drops.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

    // Merge two qualified ready sources; an enable that is high blocks its source.
    function automatic logic ready_request(
        input logic r1,
        input logic e1_n,
        input logic r2,
        input logic e2_n
    );
        return (r1 & ~e1_n) | (r2 & ~e2_n);
    endfunction

endpackage

// File: rtl/pcg_divider.sv
module pcg_divider #(
    parameter int DIV_RATIO = 3,
    parameter int HIGH_CYC  = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic cpu_clk_o,
    output logic per_clk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int PW = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
    localparam logic [PW-1:0] LAST_PH = PW'(DIV_RATIO - 1);
    localparam logic [PW-1:0] DROP_PH = PW'(HIGH_CYC - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          cpu;
        logic          per;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        rise_o = (st_q.phase == LAST_PH);
        fall_o = (st_q.phase == DROP_PH);
        if (rise_o) begin
            st_d.phase = '0;
            st_d.per   = ~st_q.per;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
        st_d.cpu = (st_d.phase < PW'(HIGH_CYC));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_clk_o = st_q.cpu;
    assign per_clk_o = st_q.per;

    AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase <= LAST_PH); // R1

    AST_PER_ON_CPU_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.per != $past(st_q.per)) |-> $rose(st_q.cpu)); // R2

    generate
        if (HIGH_CYC == 1) begin : g_single_high
            AST_CPU_HIGH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.cpu |=> !st_q.cpu); // R1
        end
    endgenerate
endmodule

// File: rtl/pcg_reset_sync.sv
module pcg_reset_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic fall_i,
    output logic reset_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              rst;
    } rs_state_t;

    rs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise_i) begin
            st_d.sync = {st_q.sync[STAGES-2:0], 1'b1};
        end
        if (fall_i) begin
            st_d.rst = ~st_q.sync[STAGES-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sync <= '0;
            st_q.rst  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign reset_o = st_q.rst;

    AST_RST_FALL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.rst) |-> $past(fall_i)); // R6

    AST_RST_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.rst |=> !st_q.rst); // R6
endmodule

// File: rtl/pcg_ready_sync.sv
module pcg_ready_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic fall_i,
    input  logic req_i,
    input  logic tolerant_i,
    output logic ready_o
);
    typedef struct packed {
        logic stage1;
        logic rdy;
    } rdy_state_t;

    rdy_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if ((rise_i || fall_i) && !req_i) begin
            st_d.stage1 = 1'b0;
            st_d.rdy    = 1'b0;
        end else if (tolerant_i) begin
            if (rise_i) st_d.stage1 = req_i;
            if (fall_i) st_d.rdy    = st_q.stage1;
        end else if (rise_i) begin
            st_d.rdy = req_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = st_q.rdy;

    AST_RDY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rdy) |-> $past(req_i)); // R7

    AST_RDY_TOL_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.rdy) && $past(tolerant_i)) |-> $past(fall_i)); // R8

    AST_RDY_DROP_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_i || fall_i) && !req_i) |=> !st_q.rdy); // R9
endmodule

// File: rtl/proc_clk_gen.sv
module proc_clk_gen #(
    parameter int DIV_RATIO  = 3,
    parameter int HIGH_CYC   = 1,
    parameter int RST_STAGES = 2
) (
    input  logic osc_in_i,
    input  logic ext_freq_i,
    input  logic sel_ext_i,
    input  logic res_n_i,
    input  logic rdy1_i,
    input  logic aen1_n_i,
    input  logic rdy2_i,
    input  logic aen2_n_i,
    input  logic async_n_i,
    output logic osc_o,
    output logic cpu_clk_o,
    output logic per_clk_o,
    output logic reset_o,
    output logic ready_o
);
    import pcg_pkg::*;

    logic src_clk;
    logic rise_evt;
    logic fall_evt;
    logic rdy_req;

    assign src_clk = sel_ext_i ? ext_freq_i : osc_in_i;
    assign osc_o   = osc_in_i;
    assign rdy_req = ready_request(rdy1_i, aen1_n_i, rdy2_i, aen2_n_i);

    pcg_divider #(
        .DIV_RATIO (DIV_RATIO),
        .HIGH_CYC  (HIGH_CYC)
    ) u_div (
        .clk       (src_clk),
        .rst_n     (res_n_i),
        .cpu_clk_o (cpu_clk_o),
        .per_clk_o (per_clk_o),
        .rise_o    (rise_evt),
        .fall_o    (fall_evt)
    );

    pcg_reset_sync #(
        .STAGES (RST_STAGES)
    ) u_rst (
        .clk     (src_clk),
        .rst_n   (res_n_i),
        .rise_i  (rise_evt),
        .fall_i  (fall_evt),
        .reset_o (reset_o)
    );

    pcg_ready_sync u_rdy (
        .clk        (src_clk),
        .rst_n      (res_n_i),
        .rise_i     (rise_evt),
        .fall_i     (fall_evt),
        .req_i      (rdy_req),
        .tolerant_i (~async_n_i),
        .ready_o    (ready_o)
    );

    AST_RESET_ON_CPU_FALL: assert property (@(posedge src_clk) disable iff (!res_n_i)
        $fell(reset_o) |-> $fell(cpu_clk_o)); // R6

    AST_READY_ONLY_ON_EDGE: assert property (@(posedge src_clk) disable iff (!res_n_i)
        (ready_o != $past(ready_o)) |-> (cpu_clk_o != $past(cpu_clk_o))); // R9
endmodule

// File: tb/proc_clk_gen_tb_top.sv
`timescale 1ns/1ps
module proc_clk_gen_tb_top;
    logic osc_in = 1'b0;
    logic ext_freq = 1'b0;
    logic sel_ext = 1'b0;
    logic res_n = 1'b0;
    logic rdy1 = 1'b0, aen1_n = 1'b1, rdy2 = 1'b0, aen2_n = 1'b1, async_n = 1'b1;
    logic osc_o, cpu_clk, per_clk, reset_o, ready_o;
    bit   use_ext = 1'b0;

    int tests = 0;
    int fails = 0;
    int     exp_q[$];
    int     act_q[$];
    string  tag_q[$];

    always #2.5 osc_in = ~osc_in;   // 200 MHz
    always #4.0 ext_freq = ~ext_freq;

    proc_clk_gen dut_i (
        .osc_in_i   (osc_in),
        .ext_freq_i (ext_freq),
        .sel_ext_i  (sel_ext),
        .res_n_i    (res_n),
        .rdy1_i     (rdy1),
        .aen1_n_i   (aen1_n),
        .rdy2_i     (rdy2),
        .aen2_n_i   (aen2_n),
        .async_n_i  (async_n),
        .osc_o      (osc_o),
        .cpu_clk_o  (cpu_clk),
        .per_clk_o  (per_clk),
        .reset_o    (reset_o),
        .ready_o    (ready_o)
    );

    // Driver side: expected value queued alongside the observed result.
    task automatic check(input string tag, input int act, input int exp);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        act_q.push_back(act);
    endtask

    // Monitor: pops and compares.
    initial begin
        forever begin
            int a, e;
            string t;
            wait (act_q.size() != 0);
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            tests++;
            if (a != e) begin
                fails++;
                $display("FAIL %s actual=%0d expected=%0d", t, a, e);
            end
        end
    end

    task automatic src_neg();
        if (use_ext) @(negedge ext_freq);
        else         @(negedge osc_in);
    endtask

    function automatic logic pick(input int which);
        return (which == 0) ? cpu_clk : per_clk;
    endfunction

    // Period and high count of a divided clock, in source cycles.
    task automatic measure(input int which, output int per, output int hi);
        logic prev, cur;
        prev = 1'b1;
        do begin
            src_neg();
            cur  = pick(which);
            if (!(cur && !prev)) prev = cur;
        end while (!(cur && !prev));
        per = 1; hi = 1; prev = 1'b1;
        forever begin
            src_neg();
            cur = pick(which);
            if (cur && !prev) break;
            per++;
            if (cur) hi++;
            prev = cur;
        end
    endtask

    task automatic apply_reset(input logic ext);
        res_n = 1'b0;
        repeat (4) @(negedge osc_in);
        sel_ext = ext;
        use_ext = ext;
        repeat (6) src_neg();
        res_n = 1'b1;
        repeat (12) src_neg();
    endtask

    task automatic after_cpu_rise();
        @(posedge cpu_clk);
        @(negedge osc_in);
    endtask

    task automatic ready_latency(output int n);
        n = 0;
        do begin
            @(negedge osc_in);
            n++;
        end while (ready_o !== 1'b1 && n < 20);
    endtask

    task automatic drop_latency(output int n);
        n = 0;
        do begin
            @(negedge osc_in);
            n++;
        end while (ready_o !== 1'b0 && n < 20);
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int per, hi, n, bad, highs;
        logic prev_cpu;

        // R5: state held during reset request
        repeat (8) @(negedge osc_in);
        check("R5 reset_o high in reset", int'(reset_o), 1);
        check("R5 cpu_clk low in reset", int'(cpu_clk), 0);
        check("R5 per_clk low in reset", int'(per_clk), 0);

        // R6: release timing and alignment with a cpu_clk fall
        res_n = 1'b1;
        n = 0;
        prev_cpu = cpu_clk;
        forever begin
            @(negedge osc_in);
            n++;
            if (reset_o == 1'b0 || n > 30) break;
            prev_cpu = cpu_clk;
        end
        check("R6 reset release edge count", n, 7);
        check("R6 cpu_clk high before release", int'(prev_cpu), 1);
        check("R6 cpu_clk low at release", int'(cpu_clk), 0);

        // R1 / R2: divided clocks from the oscillator
        measure(0, per, hi);
        check("R1 cpu period", per, 3);
        check("R1 cpu high cycles", hi, 1);
        measure(1, per, hi);
        check("R2 per period", per, 6);
        check("R2 per high cycles", hi, 3);

        // R4: undivided pass-through
        bad = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge osc_in); #1;
            if (osc_o !== 1'b1) bad++;
            @(negedge osc_in); #1;
            if (osc_o !== 1'b0) bad++;
        end
        check("R4 osc_o mismatches", bad, 0);

        // R7: source 1 with its enable high is ignored
        rdy1 = 1'b1; aen1_n = 1'b1;
        highs = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge osc_in);
            if (ready_o) highs++;
        end
        check("R7 disabled source ignored", highs, 0);
        rdy1 = 1'b0;

        // R7 / R8: source 2 enabled, direct mode
        async_n = 1'b1;
        after_cpu_rise();
        rdy2 = 1'b1; aen2_n = 1'b0;
        ready_latency(n);
        check("R7 R8 direct latency via source 2", n, 3);

        // R9: drop after a rise, direct mode
        after_cpu_rise();
        aen2_n = 1'b1;
        drop_latency(n);
        check("R9 direct drop latency", n, 1);
        rdy2 = 1'b0;

        // R8: tolerant mode via source 1
        async_n = 1'b0;
        repeat (6) @(negedge osc_in);
        after_cpu_rise();
        rdy1 = 1'b1; aen1_n = 1'b0;
        ready_latency(n);
        check("R8 tolerant latency", n, 4);

        // R9: drop right after a fall, tolerant mode: next edge is a rise
        @(negedge cpu_clk);
        @(negedge osc_in);
        rdy1 = 1'b0;
        drop_latency(n);
        check("R9 tolerant drop latency", n, 2);
        aen1_n = 1'b1;
        async_n = 1'b1;

        // R3: external source selected
        apply_reset(1'b1);
        measure(0, per, hi);
        check("R3 cpu period on external source", per, 3);
        check("R3 cpu high on external source", hi, 1);
        measure(1, per, hi);
        check("R3 per period on external source", per, 6);

        apply_reset(1'b0);
        measure(0, per, hi);
        check("R3 cpu period back on oscillator", per, 3);

        wait (act_q.size() == 0);
        #1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule